// File: doc/BRIEF.md
# Branch and Jump Next-Address Unit

This block works out where the processor fetches next. The processor has 16-bit and 32-bit instruction formats. Each cycle it receives the current program counter, the first and second instruction halfwords, the condition flags and one register value. From these it decodes four kinds of control transfer:

- a short conditional branch;
- a long PC-relative jump;
- a long jump that also saves a return address;
- a jump through a register.

Any other instruction makes the address move on sequentially. The condition table is evaluated inside the block. The only other product is a return-address write request for the register file.

All results are registered. An instruction presented with `instr_valid` high at a rising edge shows its next address and its return-address write on the outputs after that edge. Fetch, the register file and flag generation live elsewhere. The register value for an indirect jump is read by the caller from bits [4:0] of the first halfword.

Top module: `nextpc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `next_pc` becomes `RESET_PC` (default 0) and `link_we`, `link_idx` and `link_data` become 0.
- R2: At an edge where `instr_valid` is low, `next_pc` keeps its value and `link_we`, `link_idx` and `link_data` become 0. At an edge where it is high, all four outputs take the result for the presented instruction.
- R3: A first halfword matching bits[10:7]=1011 is a conditional branch with a 9-bit even displacement. The displacement is {h0[15:11], h0[6:4], 0}, sign-extended from its bit 8, which gives a range of -256 to +254. When the branch is taken, `next_pc` = `cur_pc` + displacement, and no return address is written.
- R4: The condition code h0[3:0] selects the branch condition:
  - 0: OV=1; 8: OV=0.
  - 1: CY=1; 9: CY=0.
  - 2: Z=1; 10: Z=0.
  - 3: CY|Z; 11: its complement.
  - 4: S=1; 12: S=0.
  - 5: always.
  - 13: the saturation flag is 1.
  - 6: S^OV; 14: its complement.
  - 7: (S^OV)|Z; 15: its complement.
- R5: When the branch is not taken, `next_pc` = `cur_pc` + 2.
- R6: A first halfword matching bits[10:6]=11110 is a long jump with a 22-bit even displacement. The displacement is {h0[5:0], h1[15:1], 0}, sign-extended from its bit 21, which gives a range of -2 MiB to +2 MiB-2. Then `next_pc` = `cur_pc` + displacement, and h1[0] has no effect.
- R7: For a long jump whose register field h0[15:11] is nonzero, `link_we` = 1, `link_idx` = that field and `link_data` = `cur_pc` + 4.
- R8: For a long jump whose register field is 0, `link_we` = 0, `link_idx` = 0 and `link_data` = 0.
- R9: A first halfword matching bits[15:5]=00000000011 is an indirect jump, and `next_pc` = `rs_value` with bit 0 cleared.
- R10: Any other first halfword advances `next_pc` by 4 when h0[10:9]=11 and by 2 otherwise, and writes no return address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Presented instruction is real this cycle |
| cur_pc | input | ADDR_W | Address of the presented instruction |
| instr_h0 | input | 16 | First instruction halfword |
| instr_h1 | input | 16 | Second instruction halfword |
| flag_z | input | 1 | Zero flag |
| flag_s | input | 1 | Sign flag |
| flag_ov | input | 1 | Overflow flag |
| flag_cy | input | 1 | Carry flag |
| flag_sat | input | 1 | Saturation flag |
| rs_value | input | ADDR_W | Register value for the indirect jump |
| next_pc | output | ADDR_W | Registered next fetch address |
| link_we | output | 1 | Return-address write enable |
| link_idx | output | 5 | Return-address destination register |
| link_data | output | ADDR_W | Return address |

## Verification
The bench drives the short branch at +254 and -256 and the long jump at +2 MiB-2 and -2 MiB. A design that takes a sign from the wrong bit, or scales by 4 rather than 2, lands far from the expected target at these limits.

It sweeps all sixteen condition codes over every flag combination. This exposes a swapped code pair, a wrong complement rule, or code 13 being read as "never".

An indirect jump from an odd register value shows whether bit 0 is cleared. A long jump with register field 0 shows whether a return address is wrongly written. Invalid cycles show whether the address is held and the write request is dropped.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;

  typedef enum logic [1:0] {
    CTL_SEQ   = 2'd0,
    CTL_BCOND = 2'd1,
    CTL_LONG  = 2'd2,
    CTL_INDIR = 2'd3
  } ctl_kind_e;

  typedef struct packed {
    ctl_kind_e   kind;
    logic [3:0]  cc;
    logic [4:0]  dst;
    logic        wide;
  } ctl_dec_t;

  typedef struct packed {
    logic z;
    logic s;
    logic ov;
    logic cy;
    logic sat;
  } flags_t;

  localparam int SHORT_DISP_W = 9;
  localparam int LONG_DISP_W  = 22;

endpackage

// File: rtl/nextpc_decode.sv
module nextpc_decode
  import nextpc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [15:0]       h0,
  input  logic [15:1]       h1_hi,
  output ctl_dec_t          dec,
  output logic [ADDR_W-1:0] short_disp,
  output logic [ADDR_W-1:0] long_disp
);

  localparam int SEXT_S = ADDR_W - SHORT_DISP_W;
  localparam int SEXT_L = ADDR_W - LONG_DISP_W;

  logic [SHORT_DISP_W-1:0] raw_s;
  logic [LONG_DISP_W-1:0]  raw_l;

  assign raw_s = {h0[15:11], h0[6:4], 1'b0};
  assign raw_l = {h0[5:0], h1_hi, 1'b0};

  assign short_disp = {{SEXT_S{raw_s[SHORT_DISP_W-1]}}, raw_s};
  assign long_disp  = {{SEXT_L{raw_l[LONG_DISP_W-1]}}, raw_l};

  always_comb begin
    dec.kind = CTL_SEQ;
    dec.cc   = h0[3:0];
    dec.dst  = h0[15:11];
    dec.wide = (h0[10:9] == 2'b11);
    if (h0[10:7] == 4'b1011) begin
      dec.kind = CTL_BCOND;
    end else if (h0[10:6] == 5'b11110) begin
      dec.kind = CTL_LONG;
    end else if (h0[15:5] == 11'b00000000011) begin
      dec.kind = CTL_INDIR;
    end
  end

endmodule

// File: rtl/nextpc_cond.sv
module nextpc_cond
  import nextpc_pkg::*;
(
  input  logic [3:0] cc,
  input  flags_t     fl,
  output logic       taken
);

  localparam int N_BASE   = 8;
  localparam int N_CODES  = 2 * N_BASE;
  localparam int SAT_CODE = 13;

  logic [N_BASE-1:0]  base;
  logic [N_CODES-1:0] hit;
  logic               lt;

  assign lt      = fl.s ^ fl.ov;
  assign base[0] = fl.ov;
  assign base[1] = fl.cy;
  assign base[2] = fl.z;
  assign base[3] = fl.cy | fl.z;
  assign base[4] = fl.s;
  assign base[5] = 1'b1;
  assign base[6] = lt;
  assign base[7] = lt | fl.z;

  for (genvar i = 0; i < N_CODES; i++) begin : g_code
    if (i == SAT_CODE) begin : g_sat
      assign hit[i] = fl.sat;
    end else if (i < N_BASE) begin : g_pos
      assign hit[i] = base[i];
    end else begin : g_neg
      assign hit[i] = ~base[i-N_BASE];
    end
  end

  assign taken = hit[cc];

endmodule

// File: rtl/nextpc_target.sv
module nextpc_target
  import nextpc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] pc,
  input  ctl_dec_t          dec,
  input  logic [ADDR_W-1:0] short_disp,
  input  logic [ADDR_W-1:0] long_disp,
  input  logic [ADDR_W-1:1] rs_hi,
  input  logic              taken,
  output logic [ADDR_W-1:0] target,
  output logic              lnk_we,
  output logic [4:0]        lnk_idx,
  output logic [ADDR_W-1:0] lnk_data
);

  localparam logic [ADDR_W-1:0] STEP_NARROW = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] STEP_WIDE   = ADDR_W'(4);

  logic [ADDR_W-1:0] pc_plus2;
  logic [ADDR_W-1:0] pc_plus4;
  logic [ADDR_W-1:0] pc_short;
  logic [ADDR_W-1:0] pc_long;

  assign pc_plus2 = pc + STEP_NARROW;
  assign pc_plus4 = pc + STEP_WIDE;
  assign pc_short = pc + short_disp;
  assign pc_long  = pc + long_disp;

  always_comb begin
    target   = dec.wide ? pc_plus4 : pc_plus2;
    lnk_we   = 1'b0;
    lnk_idx  = '0;
    lnk_data = '0;
    unique case (dec.kind)
      CTL_BCOND: target = taken ? pc_short : pc_plus2;
      CTL_LONG: begin
        target = pc_long;
        if (dec.dst != 5'd0) begin
          lnk_we   = 1'b1;
          lnk_idx  = dec.dst;
          lnk_data = pc_plus4;
        end
      end
      CTL_INDIR: target = {rs_hi, 1'b0};
      default: ;
    endcase
  end

endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
  import nextpc_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [15:0]       instr_h0,
  input  logic [15:0]       instr_h1,
  input  logic              flag_z,
  input  logic              flag_s,
  input  logic              flag_ov,
  input  logic              flag_cy,
  input  logic              flag_sat,
  input  logic [ADDR_W-1:0] rs_value,
  output logic [ADDR_W-1:0] next_pc,
  output logic              link_we,
  output logic [4:0]        link_idx,
  output logic [ADDR_W-1:0] link_data
);

  ctl_dec_t          dec;
  flags_t            fl;
  logic [ADDR_W-1:0] sdisp;
  logic [ADDR_W-1:0] ldisp;
  logic              taken;
  logic [ADDR_W-1:0] tgt;
  logic              c_we;
  logic [4:0]        c_idx;
  logic [ADDR_W-1:0] c_data;
  logic              unused_bits;

  assign unused_bits = instr_h1[0] ^ rs_value[0];
  assign fl = '{z: flag_z, s: flag_s, ov: flag_ov, cy: flag_cy, sat: flag_sat};

  nextpc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .h0         (instr_h0),
    .h1_hi      (instr_h1[15:1]),
    .dec        (dec),
    .short_disp (sdisp),
    .long_disp  (ldisp)
  );

  nextpc_cond u_cond (
    .cc    (dec.cc),
    .fl    (fl),
    .taken (taken)
  );

  nextpc_target #(.ADDR_W(ADDR_W)) u_tgt (
    .pc         (cur_pc),
    .dec        (dec),
    .short_disp (sdisp),
    .long_disp  (ldisp),
    .rs_hi      (rs_value[ADDR_W-1:1]),
    .taken      (taken),
    .target     (tgt),
    .lnk_we     (c_we),
    .lnk_idx    (c_idx),
    .lnk_data   (c_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      next_pc   <= RESET_PC;
      link_we   <= 1'b0;
      link_idx  <= '0;
      link_data <= '0;
    end else if (instr_valid) begin
      next_pc   <= tgt;
      link_we   <= c_we;
      link_idx  <= c_idx;
      link_data <= c_data;
    end else begin
      link_we   <= 1'b0;
      link_idx  <= '0;
      link_data <= '0;
    end
  end

endmodule

// File: rtl/nextpc_unit_chk.sv
module nextpc_unit_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              instr_valid,
  input logic [ADDR_W-1:0] cur_pc,
  input logic [15:0]       instr_h0,
  input logic [ADDR_W-1:0] next_pc,
  input logic              link_we,
  input logic [4:0]        link_idx,
  input logic [ADDR_W-1:0] link_data
);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> ($stable(next_pc) && !link_we));

  assert_branch_nolink_R3: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && instr_h0[10:7] == 4'b1011) |=> !link_we);

  assert_link_dest_R7: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (link_idx != 5'd0));

  assert_link_ret_R7: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (link_data == $past(cur_pc) + ADDR_W'(4)));

  assert_jr_nolink_R8: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && instr_h0[10:6] == 5'b11110 && instr_h0[15:11] == 5'd0)
      |=> !link_we);

  assert_indir_even_R9: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && instr_h0[15:5] == 11'b00000000011) |=> !next_pc[0]);

endmodule

bind nextpc_unit nextpc_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .instr_valid (instr_valid),
  .cur_pc      (cur_pc),
  .instr_h0    (instr_h0),
  .next_pc     (next_pc),
  .link_we     (link_we),
  .link_idx    (link_idx),
  .link_data   (link_data)
);

// File: tb/nextpc_unit_bench.sv
`timescale 1ns/1ps
module nextpc_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [31:0] cur_pc = '0;
  logic [15:0] instr_h0 = '0;
  logic [15:0] instr_h1 = '0;
  logic        flag_z = 0, flag_s = 0, flag_ov = 0, flag_cy = 0, flag_sat = 0;
  logic [31:0] rs_value = '0;
  logic [31:0] next_pc;
  logic        link_we;
  logic [4:0]  link_idx;
  logic [31:0] link_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] last_np = '0;

  always #10 clk = ~clk;

  nextpc_unit u_nextpc_unit (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .cur_pc(cur_pc),
    .instr_h0(instr_h0), .instr_h1(instr_h1), .flag_z(flag_z), .flag_s(flag_s),
    .flag_ov(flag_ov), .flag_cy(flag_cy), .flag_sat(flag_sat), .rs_value(rs_value),
    .next_pc(next_pc), .link_we(link_we), .link_idx(link_idx), .link_data(link_data)
  );

  function automatic bit cond_ok(input logic [3:0] c, input logic z, s, ov, cy, sat);
    case (c)
      4'd0:  return ov;
      4'd1:  return cy;
      4'd2:  return z;
      4'd3:  return cy | z;
      4'd4:  return s;
      4'd5:  return 1'b1;
      4'd6:  return s ^ ov;
      4'd7:  return (s ^ ov) | z;
      4'd8:  return !ov;
      4'd9:  return !cy;
      4'd10: return !z;
      4'd11: return !(cy | z);
      4'd12: return !s;
      4'd13: return sat;
      4'd14: return !(s ^ ov);
      default: return !((s ^ ov) | z);
    endcase
  endfunction

  function automatic void model(input logic [15:0] h0, h1, input logic [31:0] p, r,
                                input logic z, s, ov, cy, sat,
                                output logic [31:0] np, output logic we,
                                output logic [4:0] idx, output logic [31:0] ld,
                                output string tag);
    logic [31:0] d;
    we = 0; idx = 0; ld = 0;
    casez (h0)
      16'b?????1011???????: begin
        d = {{23{h0[15]}}, h0[15:11], h0[6:4], 1'b0};
        if (cond_ok(h0[3:0], z, s, ov, cy, sat)) begin np = p + d; tag = "R3"; end
        else begin np = p + 32'd2; tag = "R5"; end
      end
      16'b?????11110??????: begin
        d = {{10{h0[5]}}, h0[5:0], h1[15:1], 1'b0};
        np = p + d;
        if (h0[15:11] != 0) begin we = 1; idx = h0[15:11]; ld = p + 32'd4; tag = "R7"; end
        else tag = "R8";
      end
      16'b00000000011?????: begin np = r & ~32'd1; tag = "R9"; end
      default: begin np = p + ((h0[10:9] == 2'b11) ? 32'd4 : 32'd2); tag = "R10"; end
    endcase
  endfunction

  task automatic compare(input string tag, input logic [31:0] enp, input logic ewe,
                         input logic [4:0] eidx, input logic [31:0] eld);
    checks++;
    if (next_pc !== enp || link_we !== ewe || link_idx !== eidx || link_data !== eld) begin
      errors++;
      $display("FAIL %s: got np=%h we=%b idx=%0d ld=%h, expected np=%h we=%b idx=%0d ld=%h",
               tag, next_pc, link_we, link_idx, link_data, enp, ewe, eidx, eld);
    end
  endtask

  task automatic run(input logic [15:0] h0, h1, input logic [31:0] p, r,
                     input logic [4:0] fl, input string force_tag);
    logic [31:0] enp, eld; logic ewe; logic [4:0] eidx; string tag;
    instr_valid = 1; instr_h0 = h0; instr_h1 = h1; cur_pc = p; rs_value = r;
    {flag_z, flag_s, flag_ov, flag_cy, flag_sat} = fl;
    model(h0, h1, p, r, fl[4], fl[3], fl[2], fl[1], fl[0], enp, ewe, eidx, eld, tag);
    if (force_tag != "") tag = force_tag;
    @(posedge clk); @(negedge clk);
    compare(tag, enp, ewe, eidx, eld);
    last_np = enp;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] sd;
    sd = $urandom(32'h5eed_0bad);
    repeat (3) @(negedge clk);
    compare("R1", 32'h0, 1'b0, 5'd0, 32'h0);
    rst = 0;

    // R3 limits: +254 and -256
    run({5'b01111, 4'b1011, 3'b111, 4'd5}, 16'h0, 32'h0000_1000, 0, 5'b0, "R3");
    if (last_np !== 32'h0000_10FE) begin checks++; errors++;
      $display("FAIL R3: got %h expected %h", last_np, 32'h0000_10FE); end
    run({5'b10000, 4'b1011, 3'b000, 4'd5}, 16'h0, 32'h0000_1000, 0, 5'b0, "R3");
    compare("R3", 32'h0000_0F00, 0, 0, 0);
    // R5 not taken (code 2 with Z=0)
    run({5'b00011, 4'b1011, 3'b010, 4'd2}, 16'h0, 32'h0000_2000, 0, 5'b00000, "R5");
    compare("R5", 32'h0000_2002, 0, 0, 0);
    // R6 long limits
    run({5'd0, 5'b11110, 6'b011111}, 16'hFFFF, 32'h0010_0000, 0, 5'b0, "R6");
    compare("R6", 32'h002F_FFFE, 0, 0, 0);
    run({5'd0, 5'b11110, 6'b100000}, 16'h0001, 32'h0010_0000, 0, 5'b0, "R6");
    compare("R6", 32'hFFF0_0000, 0, 0, 0);
    // R7 jump and link, R8 plain
    run({5'd31, 5'b11110, 6'd0}, 16'h0040, 32'h0000_4000, 0, 5'b0, "R7");
    compare("R7", 32'h0000_4040, 1, 5'd31, 32'h0000_4004);
    run({5'd0, 5'b11110, 6'd0}, 16'h0040, 32'h0000_4000, 0, 5'b0, "R8");
    compare("R8", 32'h0000_4040, 0, 0, 0);
    // R9 odd register value
    run({11'b00000000011, 5'd7}, 16'h0, 32'h0000_5000, 32'h1234_5679, 5'b0, "R9");
    compare("R9", 32'h1234_5678, 0, 0, 0);
    // R10 narrow and wide
    run(16'h0000, 16'h0, 32'h0000_6000, 0, 5'b0, "R10");
    compare("R10", 32'h0000_6002, 0, 0, 0);
    run(16'h0620, 16'h0, 32'h0000_6000, 0, 5'b0, "R10");
    compare("R10", 32'h0000_6004, 0, 0, 0);
    // R2 invalid cycle after a link holds address and drops the write
    run({5'd9, 5'b11110, 6'd0}, 16'h0100, 32'h0000_7000, 0, 5'b0, "R7");
    instr_valid = 0; instr_h0 = {5'd3, 5'b11110, 6'd1}; cur_pc = 32'h0000_9000;
    @(posedge clk); @(negedge clk);
    compare("R2", 32'h0000_7100, 0, 0, 0);
    // R4 sweep of all codes over all flag combinations
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 32; f++)
        run({5'b00001, 4'b1011, 3'b000, 4'(c)}, 16'h0, 32'h0000_8000, 0, 5'(f), "R4");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] h0, h1; logic [31:0] p;
      h1 = 16'($urandom); p = $urandom & ~32'd1;
      case ($urandom % 5)
        0: h0 = {5'($urandom), 4'b1011, 3'($urandom), 4'($urandom)};
        1: h0 = {5'($urandom), 5'b11110, 6'($urandom)};
        2: h0 = {11'b00000000011, 5'($urandom)};
        default: h0 = 16'($urandom);
      endcase
      run(h0, h1, p, $urandom, 5'($urandom), "");
    end
    rst = 1;
    @(posedge clk); @(negedge clk);
    compare("R1", 32'h0, 0, 0, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule